// File: doc/BRIEF.md
# Programmable 64-bit Tick Timer with Self-Rearming Comparator

This peripheral keeps a free-running 64-bit up-counter that advances on a tick derived from the peripheral clock by a programmable divider. A 64-bit comparator watches the counter. Once the counter has reached or passed the compare value, the comparator raises a sticky event flag. The flag can drive a level interrupt. Software reaches every register through a single-cycle 32-bit register port. The 64-bit values are split into low and high words.

There are two compare modes. In one-shot mode an event fires once. Clearing the flag does not bring it back, even while the counter stays at or above the compare value. A fresh event needs the comparator to be rewritten or compare to be switched off and on again. In periodic mode every event adds a programmed step to the comparator. The next event then falls that many ticks later, with no software involvement.

Software reads the full counter by reading high, then low, then high again, and repeats if the high word moved. The counter increments as one 64-bit operation, so the carry from the low word into the high word happens in a single cycle.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset every register reads zero and the interrupt is low. A read from any offset outside the seven mapped words returns zero, and a write to such an offset has no effect.
- R2: With control bit 0 set, the counter advances by one every (P+1) clock cycles, where P is the divider value in control bits 15:8. With bit 0 clear, the counter holds.
- R3: Every write to the control word restarts the divider phase. The next tick then comes a full (P+1) cycles after that write, and a tick that was due on the write cycle is dropped.
- R4: The counter low word is at byte offset 0x00 and the high word at 0x04. Each can be written alone. The written value is visible on the next cycle and takes priority over a tick. An increment from low word 0xFFFFFFFF carries into the high word in the same cycle.
- R5: Compare enable is control bit 1. While it is set, the flag sets on the cycle after the unsigned 64-bit counter first becomes greater than or equal to the comparator (low word 0x10, high word 0x14). This includes a compare value that is written below the current count.
- R6: With auto-step (control bit 3) clear, an event leaves the comparator unchanged and disarms it. After the flag is cleared it stays clear until a comparator word is written or compare enable is turned off and back on.
- R7: With auto-step set, each event adds the step register (offset 0x18) to the comparator, so periodic events come every step ticks.
- R8: The flag is bit 0 of the status word at 0x0C. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged. A new event in the same cycle as the clear wins.
- R9: The interrupt output is high exactly while the flag is set and control bit 2 is set. It falls on the cycle after either one drops.
- R10: The control word at 0x08 reads back only bits 0 to 3 and 15:8. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The comparator is tested with several patterns. A compare value above the count checks that the flag appears on the cycle after equality. A value below the count checks greater-or-equal against an equality-only compare. A compare whose low word is smaller than the counter's but whose high word is larger checks that the 64 bits are compared as a whole and not half by half. Clearing the flag while the count is still past the compare value separates one-shot disarming from a flag that would simply retrigger. A periodic run followed by a read of the comparator shows whether the step was added once per event. Divider runs at ratios 1 and 4, plus a control write in the middle of a period, check both the divide ratio and the phase restart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Byte offsets of the register words (software-visible layout)
  localparam int OFF_CNT_LO = 'h00;
  localparam int OFF_CNT_HI = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_STAT   = 'h0C;
  localparam int OFF_CMP_LO = 'h10;
  localparam int OFF_CMP_HI = 'h14;
  localparam int OFF_STEP   = 'h18;

  // Control word bit positions
  localparam int CB_RUN     = 0;
  localparam int CB_CMP_EN  = 1;
  localparam int CB_IRQ_EN  = 2;
  localparam int CB_AUTO    = 3;
  localparam int CB_PSC_LSB = 8;

  // Status word bit positions
  localparam int SB_FLAG    = 0;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic             restart,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (restart || !run)       phase_d = '0;
    else if (phase_q == psc)   phase_d = '0;
    else                       phase_d = phase_q + 1'b1;
  end

  assign tick = run && !restart && (phase_q == psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // Between two ticks at a divider above zero there is always a gap
  AST_PSC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc != '0) |=> !tick); // R2
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] cnt
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = wr_lo || wr_hi || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_d[HALF_W-1:0]     = wdata;
      if (wr_hi) cnt_d[CNT_W-1:HALF_W] = wdata;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + 1'b1)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lo && !wr_hi) |=> $stable(cnt)); // R2
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int HALF_W = 32,
  parameter int STEP_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*HALF_W-1:0] cnt,
  input  logic                cmp_en,
  input  logic                auto_en,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic                wr_step,
  input  logic                clr,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] cmp,
  output logic [STEP_W-1:0]   step,
  output logic                flag
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0]  cmp_q, cmp_d, step_ext;
  logic [STEP_W-1:0] step_q;
  logic              armed_q, armed_d, flag_q, flag_d;
  logic              reached, fire;

  assign step_ext = {{(CNT_W-STEP_W){1'b0}}, step_q};
  assign reached  = (cnt >= cmp_q);
  assign fire     = cmp_en && armed_q && reached;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cmp_d[HALF_W-1:0]     = wdata;
      if (wr_hi) cmp_d[CNT_W-1:HALF_W] = wdata;
    end else if (fire && auto_en) begin
      cmp_d = cmp_q + step_ext;
    end
  end

  always_comb begin
    armed_d = armed_q;
    if (wr_lo || wr_hi || !cmp_en) armed_d = 1'b1;
    else if (fire && !auto_en)     armed_d = 1'b0;
  end

  always_comb begin
    flag_d = flag_q;
    if (fire)     flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      step_q  <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      armed_q <= armed_d;
      flag_q  <= flag_d;
      if (wr_step) step_q <= wdata[STEP_W-1:0];
    end
  end

  assign cmp  = cmp_q;
  assign step = step_q;
  assign flag = flag_q;

  AST_FLAG_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(cmp_en && reached)) |=> !flag); // R5
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !wr_lo && !wr_hi) |=> $stable(cmp)); // R6
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !auto_en && !wr_lo && !wr_hi && cmp_en) |=> !armed_q); // R6
  AST_AUTO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && auto_en && !wr_lo && !wr_hi) |=> (cmp == $past(cmp_q + step_ext))); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !flag); // R8
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int HALF_W = 32,
  parameter int PSC_W  = 8,
  parameter int STEP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int CNT_W = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFF_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFF_CNT_HI);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(OFF_CMP_LO);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(OFF_CMP_HI);
  localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(OFF_STEP);

  logic wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat, wr_cmp_lo, wr_cmp_hi, wr_step;
  assign wr_cnt_lo = bus_we && (bus_addr == A_CNT_LO);
  assign wr_cnt_hi = bus_we && (bus_addr == A_CNT_HI);
  assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
  assign wr_stat   = bus_we && (bus_addr == A_STAT);
  assign wr_cmp_lo = bus_we && (bus_addr == A_CMP_LO);
  assign wr_cmp_hi = bus_we && (bus_addr == A_CMP_HI);
  assign wr_step   = bus_we && (bus_addr == A_STEP);

  // Control register: next-state and register processes
  logic             run_q, cmp_en_q, irq_en_q, auto_q;
  logic             run_d, cmp_en_d, irq_en_d, auto_d;
  logic [PSC_W-1:0] psc_q, psc_d;

  always_comb begin
    run_d    = run_q;
    cmp_en_d = cmp_en_q;
    irq_en_d = irq_en_q;
    auto_d   = auto_q;
    psc_d    = psc_q;
    if (wr_ctrl) begin
      run_d    = bus_wdata[CB_RUN];
      cmp_en_d = bus_wdata[CB_CMP_EN];
      irq_en_d = bus_wdata[CB_IRQ_EN];
      auto_d   = bus_wdata[CB_AUTO];
      psc_d    = bus_wdata[CB_PSC_LSB +: PSC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cmp_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      auto_q   <= 1'b0;
      psc_q    <= '0;
    end else if (wr_ctrl) begin
      run_q    <= run_d;
      cmp_en_q <= cmp_en_d;
      irq_en_q <= irq_en_d;
      auto_q   <= auto_d;
      psc_q    <= psc_d;
    end
  end

  logic              tick, flag;
  logic [CNT_W-1:0]  cnt, cmp;
  logic [STEP_W-1:0] step;

  tmr_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .psc(psc_q),
    .restart(wr_ctrl), .tick(tick)
  );

  tmr_count #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(wr_cnt_lo),
    .wr_hi(wr_cnt_hi), .wdata(bus_wdata), .cnt(cnt)
  );

  tmr_compare #(.HALF_W(HALF_W), .STEP_W(STEP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_en(cmp_en_q),
    .auto_en(auto_q), .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi),
    .wr_step(wr_step), .clr(wr_stat && bus_wdata[SB_FLAG]),
    .wdata(bus_wdata), .cmp(cmp), .step(step), .flag(flag)
  );

  // Read-back words
  logic [HALF_W-1:0] ctrl_rd, stat_rd, step_rd;
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_RUN]    = run_q;
    ctrl_rd[CB_CMP_EN] = cmp_en_q;
    ctrl_rd[CB_IRQ_EN] = irq_en_q;
    ctrl_rd[CB_AUTO]   = auto_q;
    ctrl_rd[CB_PSC_LSB +: PSC_W] = psc_q;
    stat_rd = '0;
    stat_rd[SB_FLAG] = flag;
    step_rd = '0;
    step_rd[STEP_W-1:0] = step;
  end

  always_comb begin
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt[HALF_W-1:0];
      A_CNT_HI: bus_rdata = cnt[CNT_W-1:HALF_W];
      A_CTRL:   bus_rdata = ctrl_rd;
      A_STAT:   bus_rdata = stat_rd;
      A_CMP_LO: bus_rdata = cmp[HALF_W-1:0];
      A_CMP_HI: bus_rdata = cmp[CNT_W-1:HALF_W];
      A_STEP:   bus_rdata = step_rd;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_o = flag && irq_en_q;

  AST_IRQ_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> !irq_o); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[CB_IRQ_EN]) |=> !irq_o); // R9
endmodule

// File: tb/tick_cmp_timer_tb.sv
`timescale 1ns/1ps
module tick_cmp_timer_tb;
  logic        clk;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tick_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 32; a += 4) begin
      rd(a[4:0], v);
      chk("R1", "reset read", v, 32'h0);
    end
    chk("R1", "reset irq", {31'b0, irq_o}, 32'h0);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h1C, v);
    chk("R1", "unmapped read", v, 32'h0);
    rd(5'h00, v);
    chk("R1", "unmapped write no effect", v, 32'h0);
    wr(5'h08, 32'hFFFF_FF00);
    rd(5'h08, v);
    chk("R10", "ctrl readback divider", v, 32'h0000_FF00);
    wr(5'h08, 32'h0000_00F0);
    rd(5'h08, v);
    chk("R10", "ctrl readback reserved", v, 32'h0);
  endtask

  task automatic t_divider;
    logic [31:0] v;
    wr(5'h08, 32'h0000_0301);      // run, divider 3 -> every 4 cycles
    idle(10);
    rd(5'h00, v);
    chk("R2", "divide by 4", v, 32'd2);
    wr(5'h08, 32'h0);
    idle(3);
    rd(5'h00, v);
    chk("R2", "stopped counter holds", v, 32'd2);
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h1);
    idle(7);
    rd(5'h00, v);
    chk("R2", "divide by 1", v, 32'd7);
  endtask

  task automatic t_carry;
    logic [31:0] lo, hi;
    wr(5'h08, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h00, 32'hFFFF_FFFE);
    wr(5'h08, 32'h1);
    idle(2);
    rd(5'h00, lo);
    rd(5'h04, hi);
    chk("R4", "carry low", lo, 32'h0);
    chk("R4", "carry high", hi, 32'h1);
    wr(5'h00, 32'd100);            // write while running
    rd(5'h00, lo);
    chk("R4", "running write visible", lo, 32'd100);
    idle(3);
    rd(5'h00, lo);
    chk("R4", "counting after write", lo, 32'd103);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'd5);
    wr(5'h14, 32'h0);
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h7);              // run, compare, irq
    idle(5);
    rd(5'h0C, v);
    chk("R5", "no flag at equality edge", v, 32'h0);
    chk("R9", "irq low before event", {31'b0, irq_o}, 32'h0);
    idle(1);
    rd(5'h0C, v);
    chk("R5", "flag after match", v, 32'h1);
    chk("R9", "irq high", {31'b0, irq_o}, 32'h1);
    rd(5'h10, v);
    chk("R6", "comparator unchanged", v, 32'd5);
    wr(5'h08, 32'h3);              // irq disabled
    chk("R9", "irq masked", {31'b0, irq_o}, 32'h0);
    rd(5'h0C, v);
    chk("R9", "flag kept when masked", v, 32'h1);
    wr(5'h0C, 32'h0);
    rd(5'h0C, v);
    chk("R8", "write 0 keeps flag", v, 32'h1);
    wr(5'h08, 32'h7);
    chk("R9", "irq back on", {31'b0, irq_o}, 32'h1);
    wr(5'h0C, 32'h1);
    idle(3);
    rd(5'h0C, v);
    chk("R6", "no retrigger after clear", v, 32'h0);
    chk("R9", "irq low after clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_rearm;
    logic [31:0] v;
    wr(5'h10, 32'd3);              // below count -> ge fires
    rd(5'h0C, v);
    chk("R5", "no flag on write cycle", v, 32'h0);
    idle(1);
    rd(5'h0C, v);
    chk("R5", "ge fires below count", v, 32'h1);
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h5);              // compare off
    idle(2);
    rd(5'h0C, v);
    chk("R6", "no event while disabled", v, 32'h0);
    wr(5'h08, 32'h7);
    idle(1);
    rd(5'h0C, v);
    chk("R6", "rearm by enable toggle", v, 32'h1);
    wr(5'h0C, 32'h1);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'd4);
    wr(5'h14, 32'h0);
    wr(5'h18, 32'd3);
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'hF);
    idle(12);
    rd(5'h10, v);
    chk("R7", "comparator advanced thrice", v, 32'd13);
    rd(5'h14, v);
    chk("R7", "comparator high", v, 32'h0);
    rd(5'h18, v);
    chk("R7", "step readback", v, 32'd3);
    rd(5'h0C, v);
    chk("R7", "periodic flag", v, 32'h1);
  endtask

  task automatic t_wide;
    logic [31:0] v;
    wr(5'h08, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h00, 32'hFFFF_FFF0);
    wr(5'h10, 32'h0);
    wr(5'h14, 32'h1);
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h3);
    idle(15);
    rd(5'h0C, v);
    chk("R5", "64-bit compare not yet", v, 32'h0);
    idle(2);
    rd(5'h0C, v);
    chk("R5", "64-bit compare after carry", v, 32'h1);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h08, 32'h0301);
    idle(2);
    wr(5'h08, 32'h0301);           // lands on the cycle of the due tick
    rd(5'h00, v);
    chk("R3", "due tick dropped", v, 32'h0);
    idle(3);
    rd(5'h00, v);
    chk("R3", "full period after restart", v, 32'h0);
    idle(1);
    rd(5'h00, v);
    chk("R3", "tick after restart", v, 32'h1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_divider();
    t_carry();
    t_oneshot();
    t_rearm();
    t_periodic();
    t_wide();
    t_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule